// File: doc/BRIEF.md
# Privilege-Checked Register File

This block holds the architectural register state of a small processor core: sixteen 32-bit registers behind two combinational read ports and one synchronous write port. Every write through the port passes a permission check based on the current privilege level (user or supervisor). A write that is not allowed is dropped, and a one-cycle protection-fault strobe is raised so the core can trap.

Some registers are owned by hardware. The instruction pointer changes only through a dedicated next-IP port. The flags register and the three control-status registers also have side-band update ports, which the core uses on traps and returns. The upper half of the flags register holds mode and control bits, so user code cannot change it. Instruction decode, the ALU and trap sequencing sit outside this block.

Top module: `priv_regfile`

## Requirements
- R1: After reset every register reads as zero and `prot_fault_o` is low.
- R2: Index 0 always reads zero. A port write to index 0 is discarded in either mode and raises no fault.
- R3: A port write to the instruction pointer (index 9) is refused in both modes. The register keeps its value and a fault is raised. When `ip_we_i` is high, `ip_next_i` is loaded. Without it, the instruction pointer holds its value.
- R4: With `user_i`=0 (supervisor), a port write to indices 1-8 or 10-15 stores the full 32-bit data and raises no fault.
- R5: With `user_i`=1 (user), a port write to indices 1-8, 10 or 12 stores the full data. A port write to 13, 14 or 15 is refused: the register is unchanged and a fault is raised.
- R6: A user-mode port write to the flags register (index 11) updates bits 15:0 only. Bits 31:16 are kept, and no fault is raised.
- R7: `prot_fault_o` is high for exactly the one cycle after each clock edge at which a refused port write was presented. It is low in every other cycle, so back-to-back refusals give back-to-back pulses.
- R8: Both read ports are combinational and independent. A port write becomes visible on the read ports only after the clock edge that captures it.
- R9: Hardware updates take priority over a port write to the same register in the same cycle, in either mode. `flg_we_i` loads all 32 bits of the flags register. `cs_we_i[k]` loads `cs_data_i[32k+31:32k]` into index 12+k.
- R10: Index map: 0 zero, 1-8 general purpose, 9 instruction pointer, 10 stack pointer, 11 flags, 12-14 control status 0-2, 15 page offset/guard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_addr_i | input | 4 | Read port A index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 4 | Read port B index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Port write request |
| wr_addr_i | input | 4 | Port write index |
| wr_data_i | input | 32 | Port write data |
| user_i | input | 1 | Current mode: 1 user, 0 supervisor |
| ip_we_i | input | 1 | Hardware instruction-pointer load |
| ip_next_i | input | 32 | Next instruction pointer |
| flg_we_i | input | 1 | Hardware flags load |
| flg_data_i | input | 32 | Hardware flags value |
| cs_we_i | input | 3 | Hardware control-status loads, bit k for index 12+k |
| cs_data_i | input | 96 | Control-status values, 32 bits per register |
| prot_fault_o | output | 1 | Refused-write strobe |

## Verification
The assertions assume that the addresses, `user_i` and all enables are known values in every cycle after reset. They also assume that `user_i` stays stable within a cycle and is sampled at the same edge as the write it qualifies. The stimulus drives every input only at the falling edge, from a fixed-seed random source, with no X and all enables fully defined. That covers the whole index space in both modes and lets side-band loads collide with port writes. Directed sequences add the collisions, back-to-back refusals and the upper-half mask on the flags register.

// File: rtl/priv_regfile_pkg.sv
package priv_regfile_pkg;
  localparam int unsigned NUM_REGS = 16;
  localparam int unsigned ADDR_W   = $clog2(NUM_REGS);
  localparam int unsigned NUM_CS   = 3;

  localparam int unsigned IDX_ZERO  = 0;
  localparam int unsigned IDX_GP_LO = 1;
  localparam int unsigned IDX_GP_HI = 8;
  localparam int unsigned IDX_IP    = 9;
  localparam int unsigned IDX_SP    = 10;
  localparam int unsigned IDX_FLG   = 11;
  localparam int unsigned IDX_CS0   = 12;
  localparam int unsigned IDX_PAGE  = 15;

  typedef enum logic [1:0] {
    WR_DROP = 2'd0,
    WR_FULL = 2'd1,
    WR_LOW  = 2'd2,
    WR_DENY = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/regfile_wr_guard.sv
module regfile_wr_guard
  import priv_regfile_pkg::*;
(
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              user_i,
  output wr_kind_e          kind_o,
  output logic              refuse_o
);
  logic [NUM_REGS-1:0] sup_ok;
  logic [NUM_REGS-1:0] usr_ok;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_perm
    localparam bit SupOk = (i != IDX_ZERO) && (i != IDX_IP);
    localparam bit UsrOk = ((i >= IDX_GP_LO) && (i <= IDX_GP_HI)) ||
                           (i == IDX_SP) || (i == IDX_CS0) || (i == IDX_FLG);
    assign sup_ok[i] = SupOk;
    assign usr_ok[i] = UsrOk;
  end

  always_comb begin
    kind_o = WR_DROP;
    if (wr_en_i && (wr_addr_i != ADDR_W'(IDX_ZERO))) begin
      if (user_i) begin
        if (!usr_ok[wr_addr_i])                   kind_o = WR_DENY;
        else if (wr_addr_i == ADDR_W'(IDX_FLG))   kind_o = WR_LOW;
        else                                      kind_o = WR_FULL;
      end else begin
        kind_o = sup_ok[wr_addr_i] ? WR_FULL : WR_DENY;
      end
    end
  end

  assign refuse_o = (kind_o == WR_DENY);
endmodule

// File: rtl/regfile_store.sv
module regfile_store
  import priv_regfile_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  wr_kind_e                 wr_kind_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     ip_we_i,
  input  logic [DATA_W-1:0]        ip_next_i,
  input  logic                     flg_we_i,
  input  logic [DATA_W-1:0]        flg_data_i,
  input  logic [NUM_CS-1:0]        cs_we_i,
  input  logic [NUM_CS*DATA_W-1:0] cs_data_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  localparam int unsigned HALF = DATA_W / 2;

  logic [DATA_W-1:0] q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == IDX_ZERO) begin : g_zero
      assign q[i] = '0;
    end else begin : g_flop
      logic              hw_we;
      logic [DATA_W-1:0] hw_d;
      logic [DATA_W-1:0] r_q;
      logic [DATA_W-1:0] r_d;

      if (i == IDX_IP) begin : g_hw_ip
        assign hw_we = ip_we_i;
        assign hw_d  = ip_next_i;
      end else if (i == IDX_FLG) begin : g_hw_flg
        assign hw_we = flg_we_i;
        assign hw_d  = flg_data_i;
      end else if ((i >= IDX_CS0) && (i < IDX_CS0 + NUM_CS)) begin : g_hw_cs
        assign hw_we = cs_we_i[i-IDX_CS0];
        assign hw_d  = cs_data_i[(i-IDX_CS0)*DATA_W +: DATA_W];
      end else begin : g_hw_none
        assign hw_we = 1'b0;
        assign hw_d  = '0;
      end

      always_comb begin
        r_d = r_q;
        if (wr_addr_i == ADDR_W'(i)) begin
          if (wr_kind_i == WR_FULL)     r_d = wr_data_i;
          else if (wr_kind_i == WR_LOW) r_d = {r_q[DATA_W-1:HALF], wr_data_i[HALF-1:0]};
        end
        // hardware source wins over the port
        if (hw_we) r_d = hw_d;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
      end

      assign q[i] = r_q;
    end
    assign regs_o[i*DATA_W +: DATA_W] = q[i];
  end

  p_ip_port_blocked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ip_we_i |=> $stable(q[IDX_IP]));

  p_ip_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ip_we_i |=> (q[IDX_IP] == $past(ip_next_i)));

  p_flag_upper_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_kind_i == WR_LOW && wr_addr_i == ADDR_W'(IDX_FLG) && !flg_we_i)
    |=> $stable(q[IDX_FLG][DATA_W-1:HALF]));

  p_deny_keeps_page_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_kind_i == WR_DENY && wr_addr_i == ADDR_W'(IDX_PAGE)) |=> $stable(q[IDX_PAGE]));

  p_flg_hw_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flg_we_i |=> (q[IDX_FLG] == $past(flg_data_i)));
endmodule

// File: rtl/regfile_rd_port.sv
module regfile_rd_port
  import priv_regfile_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NUM_REGS*DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0]          data_o
);
  assign data_o = regs_i[addr_i*DATA_W +: DATA_W];
endmodule

// File: rtl/priv_regfile.sv
module priv_regfile
  import priv_regfile_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        rd_a_addr_i,
  output logic [DATA_W-1:0]        rd_a_data_o,
  input  logic [ADDR_W-1:0]        rd_b_addr_i,
  output logic [DATA_W-1:0]        rd_b_data_o,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     user_i,
  input  logic                     ip_we_i,
  input  logic [DATA_W-1:0]        ip_next_i,
  input  logic                     flg_we_i,
  input  logic [DATA_W-1:0]        flg_data_i,
  input  logic [NUM_CS-1:0]        cs_we_i,
  input  logic [NUM_CS*DATA_W-1:0] cs_data_i,
  output logic                     prot_fault_o
);
  wr_kind_e                   wr_kind;
  logic                       refuse;
  logic                       fault_q;
  logic [NUM_REGS*DATA_W-1:0] regs;

  regfile_wr_guard u_guard (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .user_i   (user_i),
    .kind_o   (wr_kind),
    .refuse_o (refuse)
  );

  regfile_store #(.DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_kind_i (wr_kind),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .ip_we_i   (ip_we_i),
    .ip_next_i (ip_next_i),
    .flg_we_i  (flg_we_i),
    .flg_data_i(flg_data_i),
    .cs_we_i   (cs_we_i),
    .cs_data_i (cs_data_i),
    .regs_o    (regs)
  );

  regfile_rd_port #(.DATA_W(DATA_W)) u_rd_a (
    .addr_i(rd_a_addr_i),
    .regs_i(regs),
    .data_o(rd_a_data_o)
  );

  regfile_rd_port #(.DATA_W(DATA_W)) u_rd_b (
    .addr_i(rd_b_addr_i),
    .regs_i(regs),
    .data_o(rd_b_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= refuse;
  end
  assign prot_fault_o = fault_q;

  p_zero_reads_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_addr_i == '0) |-> (rd_a_data_o == '0));

  p_ip_port_faults_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_W'(IDX_IP)) |=> prot_fault_o);

  p_user_page_faults_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && user_i && wr_addr_i == ADDR_W'(IDX_PAGE)) |=> prot_fault_o);

  p_sup_no_fault_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !user_i && wr_addr_i != ADDR_W'(IDX_IP)) |=> !prot_fault_o);

  p_idle_no_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !prot_fault_o);
endmodule

// File: tb/priv_regfile_test.sv
`timescale 1ns/1ps
module priv_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ra = '0, rb = '0;
  logic [31:0] rda, rdb;
  logic        we = 1'b0;
  logic [3:0]  wa = '0;
  logic [31:0] wd = '0;
  logic        usr = 1'b0;
  logic        ipw = 1'b0;
  logic [31:0] ipd = '0;
  logic        fw = 1'b0;
  logic [31:0] fd = '0;
  logic [2:0]  cw = '0;
  logic [95:0] cd = '0;
  logic        fault;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [16];

  always #2.5 clk = ~clk;

  priv_regfile uut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_addr_i(ra), .rd_a_data_o(rda),
    .rd_b_addr_i(rb), .rd_b_data_o(rdb),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd), .user_i(usr),
    .ip_we_i(ipw), .ip_next_i(ipd),
    .flg_we_i(fw), .flg_data_i(fd),
    .cs_we_i(cw), .cs_data_i(cd),
    .prot_fault_o(fault)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // 0 drop, 1 full, 2 low half, 3 refuse (index map per R10)
  function automatic int perm(input logic [3:0] a, input logic u);
    if (a == 0) return 0;
    if (!u) return (a == 9) ? 3 : 1;
    if (a >= 1 && a <= 8) return 1;
    if (a == 10 || a == 12) return 1;
    if (a == 11) return 2;
    return 3;
  endfunction

  // called just after a falling edge
  task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d, input logic u,
                      input logic [3:0] pa, input logic [3:0] pb, input string tag);
    int p;
    bit exp_fault;
    we = w; wa = a; wd = d; usr = u; ra = pa; rb = pb;
    #1;
    // R8: write not yet visible
    chk(rda == model[pa], "R8 pre-edge port A", rda, model[pa]);
    chk(rdb == model[pb], "R8 pre-edge port B", rdb, model[pb]);
    p = w ? perm(a, u) : 0;
    exp_fault = (p == 3);
    if (p == 1) model[a] = d;
    else if (p == 2) model[a] = {model[a][31:16], d[15:0]};
    if (ipw) model[9] = ipd;
    if (fw) model[11] = fd;
    for (int k = 0; k < 3; k++) if (cw[k]) model[12+k] = cd[k*32 +: 32];
    model[0] = '0;
    @(negedge clk);
    chk(rda == model[pa], tag, rda, model[pa]);
    chk(rdb == model[pb], tag, rdb, model[pb]);
    chk(fault == exp_fault, {tag, " fault R7"}, {31'd0, fault}, {31'd0, exp_fault});
    ipw = 1'b0; fw = 1'b0; cw = '0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 16; i += 2) step(1'b0, 4'd0, 32'd0, 1'b0, 4'(i), 4'(i+1), "R1 reset read");
    chk(fault == 1'b0, "R1 fault low", {31'd0, fault}, 32'd0);

    // R4 supervisor fills every writable index; R3 IP refused
    for (int i = 1; i < 16; i++)
      step(1'b1, 4'(i), 32'hA500_0000 + i, 1'b0, 4'(i), 4'd9, (i == 9) ? "R3 sup IP refused" : "R4 sup write");

    // R2 zero register
    step(1'b1, 4'd0, 32'hFFFF_FFFF, 1'b0, 4'd0, 4'd0, "R2 sup zero write");
    step(1'b1, 4'd0, 32'h1234_5678, 1'b1, 4'd0, 4'd1, "R2 user zero write");

    // R3 IP in user mode, then via side-band
    step(1'b1, 4'd9, 32'hDEAD_BEEF, 1'b1, 4'd9, 4'd9, "R3 user IP refused");
    ipw = 1'b1; ipd = 32'h0000_4000;
    step(1'b0, 4'd0, 32'd0, 1'b0, 4'd9, 4'd9, "R3 IP side-band");

    // R5 user writable and refused sets
    step(1'b1, 4'd3, 32'h1111_0003, 1'b1, 4'd3, 4'd3, "R5 user GP");
    step(1'b1, 4'd10, 32'h1111_000A, 1'b1, 4'd10, 4'd10, "R5 user SP");
    step(1'b1, 4'd12, 32'h1111_000C, 1'b1, 4'd12, 4'd12, "R5 user CS0");
    step(1'b1, 4'd13, 32'h2222_000D, 1'b1, 4'd13, 4'd13, "R5 user CS1 refused");
    step(1'b1, 4'd14, 32'h2222_000E, 1'b1, 4'd14, 4'd14, "R5 user CS2 refused");
    step(1'b1, 4'd15, 32'h2222_000F, 1'b1, 4'd15, 4'd15, "R5 user page refused");
    step(1'b0, 4'd15, 32'h0, 1'b1, 4'd15, 4'd13, "R7 fault drops");

    // R6 flags half mask
    step(1'b1, 4'd11, 32'h1234_5678, 1'b0, 4'd11, 4'd11, "R6 sup flags full");
    step(1'b1, 4'd11, 32'hAAAA_5555, 1'b1, 4'd11, 4'd11, "R6 user flags low half");
    chk(rda == 32'h1234_5555, "R6 flags value", rda, 32'h1234_5555);

    // R9 collisions
    fw = 1'b1; fd = 32'h0002_0001;
    step(1'b1, 4'd11, 32'hFFFF_FFFF, 1'b0, 4'd11, 4'd11, "R9 flags hw wins");
    cw = 3'b101; cd = {32'hC2C2_C2C2, 32'hC1C1_C1C1, 32'hC0C0_C0C0};
    step(1'b1, 4'd12, 32'h0BAD_0BAD, 1'b1, 4'd12, 4'd14, "R9 cs hw wins");
    cw = 3'b010; cd = {32'h0, 32'h5151_5151, 32'h0};
    step(1'b1, 4'd13, 32'h0BAD_0BAD, 1'b1, 4'd13, 4'd12, "R9 cs1 hw in user");
    chk(rda == 32'h5151_5151, "R9 cs1 value", rda, 32'h5151_5151);

    // R7 back-to-back refusals then legal
    step(1'b1, 4'd9, 32'h1, 1'b0, 4'd9, 4'd1, "R7 refuse 1");
    step(1'b1, 4'd15, 32'h2, 1'b1, 4'd15, 4'd1, "R7 refuse 2");
    step(1'b1, 4'd1, 32'h3, 1'b1, 4'd1, 4'd15, "R7 legal after refuse");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      ipw = ($urandom % 5) == 0; ipd = $urandom;
      fw  = ($urandom % 8) == 0; fd = $urandom;
      cw  = 3'($urandom) & 3'($urandom) & 3'($urandom);
      cd  = {$urandom, $urandom, $urandom};
      step(($urandom % 10) < 7, 4'($urandom), $urandom, 1'($urandom),
           4'($urandom), 4'($urandom), "R8 R5 R4 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule